// File: doc/BRIEF.md
# XOR Interleave Target Selector

This block decides which member of a host-bridge interleave set serves a given 52-bit host physical address. It works for power-of-two interleave sets (1, 2, 4, 8 and 16 members) and for three-based sets (3, 6 and 12 members). Each low bit of the target index is the parity of the address masked by its own programmable XOR map. For three-based sets, the remainder modulo 3 of a masked upper address field sits directly above the XOR bits.

A lookup is requested with `lookup_i`. One clock later the block returns the index, a valid flag and an error flag. An error is raised for an illegal ways code, an illegal granularity code, or a window base or size that is not 256 MiB aligned. The lookup address is either `addr_i` itself, or it is derived from the window base and a position number. The second form is used to find which member serves slot p of a window. Up to four XOR maps are loaded through a one-port write interface.

Top module: `xts_tgt_sel`

## Requirements
- R1: After reset, `vld_o`, `err_o` and `tgt_o` are 0 and all XOR maps are 0, so a 2-way lookup (ways code 1) of any address returns index 0.
- R2: `vld_o` is 1 exactly one clock after a cycle with `lookup_i` high. In a cycle after no request, `vld_o`, `err_o` and `tgt_o` are all 0.
- R3: Ways codes map as follows: 0,1,2,3,4 to 1,2,4,8,16 members, and 8,9,10 to 3,6,12 members. Any other code gives `err_o`=1 with `tgt_o`=0.
- R4: Granularity code g selects 256<<g bytes for g = 0..6. A code above 6 gives `err_o`=1 with `tgt_o`=0.
- R5: Any nonzero bit in bits 27:0 of `win_base_i` or `win_size_i` gives `err_o`=1 with `tgt_o`=0.
- R6: For ways codes 1..4 (code e), bit i of `tgt_o` is the XOR reduction of (address AND map i) for i < e. All higher bits are 0.
- R7: For ways code 8 (3 members), `tgt_o` equals A mod 3. A is the address with every bit below position (ways code + granularity code + 8) cleared. No map is used.
- R8: For ways codes 9 and 10, the low n = code-8 bits are XOR parities as in R6, and bits n+1:n carry the R7 remainder.
- R9: For ways code 0 (1 member), `tgt_o` is 0 whatever the maps and address.
- R10: With `pos_sel_i`=1, the lookup address is `win_base_i` + `pos_i` × (256<<g), truncated to 52 bits, instead of `addr_i`.
- R11: `map_we_i` writes `map_data_i` into map `map_sel_i` at the clock edge. A lookup in the same cycle still uses the previous map value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_i | input | 1 | Lookup request |
| addr_i | input | 52 | Host physical address |
| pos_sel_i | input | 1 | Use window base plus position as lookup address |
| pos_i | input | 4 | Position within the window |
| win_base_i | input | 52 | Window base address |
| win_size_i | input | 52 | Window size |
| ways_code_i | input | 4 | Encoded interleave ways |
| gran_code_i | input | 4 | Encoded interleave granularity |
| map_we_i | input | 1 | XOR map write enable |
| map_sel_i | input | 2 | XOR map number to write |
| map_data_i | input | 52 | XOR map write data |
| tgt_o | output | 4 | Target index |
| vld_o | output | 1 | Result valid |
| err_o | output | 1 | Illegal configuration |

## Verification
A map write and a lookup that reads the same map can land in one clock. The bench drives both at the same falling edge, using a map value that flips the parity of the chosen address. It then requires the result to match the old map, and a lookup in the next cycle to match the new one. Besides this, the bench sweeps every ways and granularity code over a set of addresses, and every position of three-based windows. Each result is compared with parities and remainders computed arithmetically in the bench.

// File: rtl/xts_pkg.sv
package xts_pkg;

  typedef struct packed {
    logic       ok;
    logic [2:0] nx;
    logic       use_mod;
  } ways_dec_t;

  // codes 0..4: 2^c ways (c XOR bits); 8..10: 3*2^(c-8) ways
  function automatic ways_dec_t dec_ways(input logic [3:0] c);
    ways_dec_t d;
    d = '0;
    if (c <= 4'd4) begin
      d.ok = 1'b1;
      d.nx = c[2:0];
    end else if (c >= 4'd8 && c <= 4'd10) begin
      d.ok      = 1'b1;
      d.nx      = 3'(c - 4'd8);
      d.use_mod = 1'b1;
    end
    return d;
  endfunction

endpackage

// File: rtl/xts_map_regs.sv
module xts_map_regs #(
  parameter int ADDR_W = 52,
  parameter int NMAP   = 4,
  localparam int SEL_W = (NMAP > 1) ? $clog2(NMAP) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [ADDR_W-1:0]             data_i,
  output logic [NMAP-1:0][ADDR_W-1:0]   maps_o
);

  for (genvar i = 0; i < NMAP; i++) begin : g_map
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        maps_o[i] <= '0;
      else if (we_i && (sel_i == SEL_W'(i)))
        maps_o[i] <= data_i;
    end
  end

endmodule

// File: rtl/xts_addr_gen.sv
module xts_addr_gen #(
  parameter int ADDR_W  = 52,
  parameter int POS_W   = 4,
  parameter int ALIGN_W = 28,
  parameter int GMAX    = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic              pos_sel_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [3:0]        gran_code_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic              gran_err_o,
  output logic              align_err_o
);

  logic [ADDR_W-1:0] step;

  // position p maps to base + p * (256 << g)
  assign step        = ADDR_W'(pos_i) << (5'd8 + 5'(gran_code_i));
  assign eff_addr_o  = pos_sel_i ? (base_i + step) : addr_i;
  assign gran_err_o  = (gran_code_i > 4'(GMAX));
  assign align_err_o = (|base_i[ALIGN_W-1:0]) | (|size_i[ALIGN_W-1:0]);

endmodule

// File: rtl/xts_mod3.sv
module xts_mod3 #(
  parameter int W = 52
) (
  input  logic [W-1:0] val_i,
  output logic [1:0]   rem_o
);

  localparam int PW = W + (W % 2);
  localparam int ND = PW / 2;
  localparam int SW = $clog2(3 * ND + 1);
  localparam int NF = SW;

  logic [PW-1:0] padded;
  logic [SW-1:0] stage [NF+1];

  // 4 == 1 (mod 3): digit sum in base 4 keeps the remainder
  function automatic logic [SW-1:0] fold(input logic [SW-1:0] v);
    logic [SW:0]   vp;
    logic [SW-1:0] s;
    vp = {1'b0, v};
    s  = '0;
    for (int k = 0; k < SW; k += 2)
      s = s + SW'(vp[k +: 2]);
    return s;
  endfunction

  assign padded = PW'(val_i);

  always_comb begin
    logic [SW-1:0] acc;
    acc = '0;
    for (int k = 0; k < ND; k++)
      acc = acc + SW'(padded[2*k +: 2]);
    stage[0] = acc;
  end

  for (genvar f = 0; f < NF; f++) begin : g_fold
    assign stage[f+1] = fold(stage[f]);
  end

  assign rem_o = (stage[NF] == SW'(3)) ? 2'd0 : stage[NF][1:0];

endmodule

// File: rtl/xts_index.sv
module xts_index
  import xts_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int NMAP   = 4,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NMAP-1:0][ADDR_W-1:0] maps_i,
  input  logic [3:0]                  ways_code_i,
  input  logic [3:0]                  gran_code_i,
  output logic [IDX_W-1:0]            idx_o,
  output logic                        ways_err_o
);

  ways_dec_t         dec;
  logic [NMAP-1:0]   par;
  logic [NMAP-1:0]   xor_bits;
  logic [5:0]        cut;
  logic [ADDR_W-1:0] masked;
  logic [1:0]        rem;

  assign dec        = dec_ways(ways_code_i);
  assign ways_err_o = ~dec.ok;

  for (genvar i = 0; i < NMAP; i++) begin : g_par
    assign par[i]      = ^(addr_i & maps_i[i]);
    assign xor_bits[i] = par[i] & (3'(i) < dec.nx);
  end

  // upper field above ways code + granularity code + 256 B
  assign cut    = 6'(ways_code_i) + 6'(gran_code_i) + 6'd8;
  assign masked = addr_i & ({ADDR_W{1'b1}} << cut);

  xts_mod3 #(.W(ADDR_W)) u_mod3 (
    .val_i (masked),
    .rem_o (rem)
  );

  always_comb begin
    idx_o = IDX_W'(xor_bits);
    if (dec.use_mod)
      idx_o = idx_o | (IDX_W'(rem) << dec.nx);
  end

endmodule

// File: rtl/xts_tgt_sel.sv
module xts_tgt_sel #(
  parameter int ADDR_W  = 52,
  parameter int NMAP    = 4,
  parameter int IDX_W   = 4,
  parameter int POS_W   = 4,
  parameter int ALIGN_W = 28,
  parameter int GMAX    = 6,
  localparam int SEL_W  = (NMAP > 1) ? $clog2(NMAP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pos_sel_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [ADDR_W-1:0] win_base_i,
  input  logic [ADDR_W-1:0] win_size_i,
  input  logic [3:0]        ways_code_i,
  input  logic [3:0]        gran_code_i,
  input  logic              map_we_i,
  input  logic [SEL_W-1:0]  map_sel_i,
  input  logic [ADDR_W-1:0] map_data_i,
  output logic [IDX_W-1:0]  tgt_o,
  output logic              vld_o,
  output logic              err_o
);

  logic [NMAP-1:0][ADDR_W-1:0] maps;
  logic [ADDR_W-1:0]           eff_addr;
  logic                        gran_err, align_err, ways_err, cfg_err;
  logic [IDX_W-1:0]            idx;

  xts_map_regs #(.ADDR_W(ADDR_W), .NMAP(NMAP)) u_maps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (map_we_i),
    .sel_i  (map_sel_i),
    .data_i (map_data_i),
    .maps_o (maps)
  );

  xts_addr_gen #(
    .ADDR_W(ADDR_W), .POS_W(POS_W), .ALIGN_W(ALIGN_W), .GMAX(GMAX)
  ) u_agen (
    .addr_i      (addr_i),
    .base_i      (win_base_i),
    .size_i      (win_size_i),
    .pos_sel_i   (pos_sel_i),
    .pos_i       (pos_i),
    .gran_code_i (gran_code_i),
    .eff_addr_o  (eff_addr),
    .gran_err_o  (gran_err),
    .align_err_o (align_err)
  );

  xts_index #(.ADDR_W(ADDR_W), .NMAP(NMAP), .IDX_W(IDX_W)) u_idx (
    .addr_i      (eff_addr),
    .maps_i      (maps),
    .ways_code_i (ways_code_i),
    .gran_code_i (gran_code_i),
    .idx_o       (idx),
    .ways_err_o  (ways_err)
  );

  assign cfg_err = ways_err | gran_err | align_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      err_o <= 1'b0;
      tgt_o <= '0;
    end else begin
      vld_o <= lookup_i;
      err_o <= lookup_i & cfg_err;
      tgt_o <= (lookup_i && !cfg_err) ? idx : '0;
    end
  end

endmodule

// File: rtl/xts_chk.sv
module xts_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_i,
  input logic [3:0]       ways_code_i,
  input logic [IDX_W-1:0] tgt_o,
  input logic             vld_o,
  input logic             err_o
);

  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r2_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (vld_o == $past(lookup_i)));

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (!err_o && tgt_o == '0));

  a_r3_err_zero_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (vld_o && tgt_o == '0));

  a_r9_one_way_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && vld_o && $past(ways_code_i) == 4'd0) |-> (tgt_o == '0));

  a_r7_three_way_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && vld_o && !err_o && $past(ways_code_i) == 4'd8) |-> (tgt_o < IDX_W'(3)));

  a_r8_six_way_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && vld_o && !err_o && $past(ways_code_i) == 4'd9) |-> (tgt_o < IDX_W'(6)));

  a_r8_twelve_way_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && vld_o && !err_o && $past(ways_code_i) == 4'd10) |-> (tgt_o < IDX_W'(12)));

endmodule

bind xts_tgt_sel xts_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lookup_i    (lookup_i),
  .ways_code_i (ways_code_i),
  .tgt_o       (tgt_o),
  .vld_o       (vld_o),
  .err_o       (err_o)
);

// File: tb/sim_xts_tgt_sel.sv
`timescale 1ns/1ps
module sim_xts_tgt_sel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup = 1'b0;
  logic [51:0] addr = '0;
  logic        pos_sel = 1'b0;
  logic [3:0]  pos = '0;
  logic [51:0] base = '0;
  logic [51:0] size = '0;
  logic [3:0]  ways = '0;
  logic [3:0]  gran = '0;
  logic        map_we = 1'b0;
  logic [1:0]  map_sel = '0;
  logic [51:0] map_data = '0;
  logic [3:0]  tgt;
  logic        vld, err;

  int total = 0;
  int bad = 0;
  logic [51:0] mdl_map [4];

  always #2.5 clk = ~clk;

  xts_tgt_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .lookup_i(lookup), .addr_i(addr),
    .pos_sel_i(pos_sel), .pos_i(pos), .win_base_i(base), .win_size_i(size),
    .ways_code_i(ways), .gran_code_i(gran), .map_we_i(map_we),
    .map_sel_i(map_sel), .map_data_i(map_data),
    .tgt_o(tgt), .vld_o(vld), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns {err, idx}
  function automatic logic [4:0] model(input logic [51:0] a, input int w, input int g,
                                       input logic [51:0] b, input logic [51:0] s);
    logic [3:0]  idx;
    logic [51:0] m;
    int nx;
    bit wok, md;
    wok = (w <= 4) || (w >= 8 && w <= 10);
    if (!wok || g > 6 || b[27:0] != 0 || s[27:0] != 0) return 5'h10;
    md  = (w >= 8);
    nx  = md ? w - 8 : w;
    idx = '0;
    for (int i = 0; i < nx; i++) idx[i] = ^(a & mdl_map[i]);
    if (md) begin
      m = (a >> (w + g + 8)) << (w + g + 8);
      idx = idx | 4'((m % 3) << nx);
    end
    return {1'b0, idx};
  endfunction

  function automatic string tag(input int w, input int g, input logic [51:0] b, input logic [51:0] s);
    if (!((w <= 4) || (w >= 8 && w <= 10))) return "R3";
    if (g > 6) return "R4";
    if (b[27:0] != 0 || s[27:0] != 0) return "R5";
    if (w == 0) return "R9";
    if (w == 8) return "R7";
    if (w >= 9) return "R8";
    return "R6";
  endfunction

  task automatic write_map(input int sel, input logic [51:0] d);
    @(negedge clk);
    map_we = 1'b1; map_sel = 2'(sel); map_data = d;
    @(negedge clk);
    map_we = 1'b0;
    mdl_map[sel] = d;
  endtask

  task automatic lookup_chk(input logic [51:0] a, input int w, input int g, input bit ps,
                            input int p, input logic [51:0] b, input logic [51:0] s,
                            input string req);
    logic [4:0]  exp;
    logic [51:0] ea;
    @(negedge clk);
    addr = a; ways = 4'(w); gran = 4'(g); pos_sel = ps; pos = 4'(p);
    base = b; size = s; lookup = 1'b1;
    ea  = ps ? 52'(b + (52'(p) << (8 + g))) : a;
    exp = model(ea, w, g, b, s);
    @(negedge clk);
    lookup = 1'b0;
    chk(vld == 1'b1, "R2", int'(vld), 1);
    chk(err == exp[4], req, int'(err), int'(exp[4]));
    chk(tgt == exp[3:0], req, int'(tgt), int'(exp[3:0]));
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [51:0] a0, nm, old;
    for (int i = 0; i < 4; i++) mdl_map[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(vld == 1'b0, "R1", int'(vld), 0);
    chk(err == 1'b0, "R1", int'(err), 0);
    chk(tgt == 4'd0, "R1", int'(tgt), 0);
    rst_n = 1'b1;
    // R1 maps cleared: 2-way lookup of all ones gives 0
    lookup_chk('1, 1, 0, 1'b0, 0, '0, '0, "R1");
    // R2 idle after request
    @(negedge clk);
    chk(vld == 1'b0 && err == 1'b0 && tgt == 4'd0, "R2", int'(vld), 0);

    write_map(0, 52'h0_0000_0001_0100);
    write_map(1, 52'h0_0000_0022_0200);
    write_map(2, 52'h0_0F00_0004_0400);
    write_map(3, 52'hA_0000_0088_0800);

    // sweep of all ways and granularity codes (R3 R4 R6 R7 R8 R9)
    for (int w = 0; w < 16; w++)
      for (int g = 0; g < 8; g++)
        for (int k = 0; k < 6; k++) begin
          a0 = 52'(64'h9E3779B97F4A7C15 * 64'(k + 1 + w * 7 + g * 3));
          lookup_chk(a0, w, g, 1'b0, 0, '0, '0, tag(w, g, '0, '0));
        end

    // R5 misaligned base or size
    lookup_chk(52'h123_4567, 2, 1, 1'b0, 0, 52'h0000_1000_0000 | 52'h800_0000, '0, "R5");
    lookup_chk(52'h123_4567, 2, 1, 1'b0, 0, 52'h0000_1000_0000, 52'h0000_1000_0001, "R5");
    lookup_chk(52'h123_4567, 2, 1, 1'b0, 0, 52'h0000_3000_0000, 52'h0000_4000_0000, "R5");

    // R10 position mode over three-based and power-of-two windows
    for (int g = 0; g < 7; g++)
      for (int p = 0; p < 16; p++) begin
        lookup_chk('0, 10, g, 1'b1, p, 52'h0_0003_5000_0000, 52'h0_0001_0000_0000, "R10");
        lookup_chk('0, 8, g, 1'b1, p, 52'h0_0070_0000_0000, 52'h0_0000_3000_0000, "R10");
        lookup_chk('0, 4, g, 1'b1, p, 52'h0_0001_1000_0000, 52'h0_0000_1000_0000, "R10");
      end

    // R11 write and lookup in the same cycle use the old map
    a0  = 52'h0_0000_0000_0100;
    old = mdl_map[0];
    nm  = 52'h0;
    @(negedge clk);
    addr = a0; ways = 4'd1; gran = 4'd0; pos_sel = 1'b0; base = '0; size = '0;
    lookup = 1'b1; map_we = 1'b1; map_sel = 2'd0; map_data = nm;
    @(negedge clk);
    lookup = 1'b0; map_we = 1'b0;
    chk(tgt == 4'(^(a0 & old)), "R11", int'(tgt), int'(^(a0 & old)));
    mdl_map[0] = nm;
    lookup_chk(a0, 1, 0, 1'b0, 0, '0, '0, "R11");
    chk(tgt == 4'd0, "R11", int'(tgt), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule